// File: doc/BRIEF.md
# Burst Bus Target with Register Storage

This block is the target side of a synchronous, clocked burst bus that shares one set of lines for address and data. An initiator opens a transaction by raising a frame line. In that first cycle it places a word address on the shared lines and a command on a small command field. If the address lies inside the target's window and the command is a read or a write, the target claims the transaction. It then moves one word per clock edge on which both the initiator's ready line and its own ready line are high. The word address steps by one after every word that moves.

The target holds a small parameterised register file. Reads wait out one turnaround cycle and then a parameterised number of wait states before the first word is offered. Writes are accepted from the first cycle after the address phase. The initiator ends a burst by dropping frame for the last word. The target cuts a burst short with a stop indication when the next word would fall past the top of its window. A transaction aimed elsewhere is left completely alone.

Top module: `bt_target`

## Requirements
- R1: While reset is held, and after it is released with no transaction under way, `sel_o`, `trdy_o`, `stop_o` and `ad_oe_o` are low. Every storage word reads back as zero after reset.
- R2: A transaction is claimed when `frame_i` is sampled high after being low, the command is read (4'b0110) or write (4'b0111), and the word address on `ad_i` lies in [BASE, BASE+DEPTH). `sel_o` is then high from the next cycle until the transaction ends.
- R3: For an address outside the window, or for any other command value, `sel_o`, `trdy_o`, `stop_o` and `ad_oe_o` stay low and no storage word changes.
- R4: On a write, `trdy_o` is high from the first cycle after the address phase. On every edge with `trdy_o` and `irdy_i` both high, `ad_i` is stored at the current word, and the word index then advances by one.
- R5: An edge with `irdy_i` low moves no word and leaves the word index unchanged.
- R6: On a read, `ad_oe_o` is low in the first cycle after the address phase (turnaround). It is high in every later cycle of the data phases.
- R7: On a read, `trdy_o` stays low for RD_WAIT cycles after the turnaround cycle, with `ad_oe_o` high, and is high from then on. While `ad_oe_o` is high, `ad_o` shows the word at the current index.
- R8: The transfer on an edge where `frame_i` is low and both ready lines are high is the last one. `sel_o`, `trdy_o` and `ad_oe_o` are low in the next cycle.
- R9: When a word moves at the top index of the window with `frame_i` still high, the next cycle shows `stop_o` high and `trdy_o` low. `stop_o` holds until `frame_i` is sampled low, and in the following cycle all outputs are low.
- R10: `trdy_o` and `stop_o` are never high together, and `ad_oe_o` is never high during a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all bus lines sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_i | input | 1 | Initiator frame; high while more than one word remains |
| cmd_i | input | 4 | Command, valid in the address phase |
| irdy_i | input | 1 | Initiator ready |
| ad_i | input | DW | Shared lines as seen by the target: address, then write data |
| ad_o | output | DW | Read data driven onto the shared lines |
| ad_oe_o | output | 1 | Output enable for `ad_o` |
| sel_o | output | 1 | Transaction claimed |
| trdy_o | output | 1 | Target ready |
| stop_o | output | 1 | Target requests the burst to end |

## Verification
Two things can happen on the same edge: the initiator's final transfer, marked by `frame_i` low, and the target's end-of-window disconnect, triggered by a transfer at the top word. Directed bursts of exactly DEPTH words starting at BASE, for both read and write, make the last word land on the top index with `frame_i` already low. The bench then requires a clean end: no `stop_o`, and `sel_o` low in the next cycle. Bursts that start a few words below the top and ask for more words than remain exercise the disconnect path, where `stop_o` must appear and hold until frame falls.

// File: rtl/bt_pkg.sv
package bt_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_TURN,
      ST_WAIT,
      ST_XFER,
      ST_STOP
   } bt_state_e;

   localparam logic [3:0] CMD_RD = 4'b0110;
   localparam logic [3:0] CMD_WR = 4'b0111;
endpackage

// File: rtl/bt_decode.sv
module bt_decode #(
   parameter int          DW    = 32,
   parameter int          DEPTH = 16,
   parameter int unsigned BASE  = 64,
   localparam int         IW    = $clog2(DEPTH)
) (
   input  logic [DW-1:0] addr,
   input  logic [3:0]    cmd,
   output logic          hit,
   output logic          is_rd,
   output logic [IW-1:0] idx
);
   import bt_pkg::*;

   localparam logic [DW-1:0] LO = DW'(BASE);
   localparam logic [DW-1:0] HI = DW'(BASE + DEPTH - 1);

   logic in_win;
   logic cmd_ok;

   assign in_win = (addr >= LO) && (addr <= HI);
   assign cmd_ok = (cmd == CMD_RD) || (cmd == CMD_WR);
   assign hit    = in_win && cmd_ok;
   assign is_rd  = (cmd == CMD_RD);
   // window base is aligned to DEPTH, so the low bits are the word index
   assign idx    = addr[IW-1:0];
endmodule

// File: rtl/bt_regfile.sv
module bt_regfile #(
   parameter int DW    = 32,
   parameter int DEPTH = 16,
   localparam int IW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [IW-1:0] widx,
   input  logic [DW-1:0] wdata,
   input  logic [IW-1:0] ridx,
   output logic [DW-1:0] rdata
);
   logic [DW-1:0] words [DEPTH];

   for (genvar g = 0; g < DEPTH; g++) begin : g_word
      logic [DW-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                        q <= '0;
         else if (we && (widx == IW'(g)))   q <= wdata;
      end
      assign words[g] = q;
   end

   assign rdata = words[ridx];
endmodule

// File: rtl/bt_ctrl.sv
module bt_ctrl #(
   parameter int DEPTH   = 16,
   parameter int RD_WAIT = 2,
   localparam int IW     = $clog2(DEPTH),
   localparam int WW     = (RD_WAIT < 2) ? 1 : $clog2(RD_WAIT)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          frame_i,
   input  logic          irdy_i,
   input  logic          hit,
   input  logic          dec_rd,
   input  logic [IW-1:0] dec_idx,
   output logic          sel_o,
   output logic          trdy_o,
   output logic          stop_o,
   output logic          ad_oe_o,
   output logic          we,
   output logic [IW-1:0] idx
);
   import bt_pkg::*;

   localparam logic [IW-1:0] LAST = IW'(DEPTH - 1);

   bt_state_e state, nstate;
   logic      is_rd;
   logic      frame_q;
   logic      addr_phase;
   logic      moved;
   logic      wait_last;

   assign addr_phase = frame_i && !frame_q;
   assign moved      = (state == ST_XFER) && irdy_i;

   if (RD_WAIT == 0) begin : g_nowait
      assign wait_last = 1'b1;
   end else begin : g_wait
      logic [WW-1:0] wcnt;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                 wcnt <= '0;
         else if (state != ST_WAIT)  wcnt <= '0;
         else                        wcnt <= wcnt + 1'b1;
      end
      assign wait_last = (wcnt == WW'(RD_WAIT - 1));
   end

   always_comb begin
      nstate = state;
      unique case (state)
         ST_IDLE: if (addr_phase && hit) nstate = dec_rd ? ST_TURN : ST_XFER;
         ST_TURN: nstate = (RD_WAIT == 0) ? ST_XFER : ST_WAIT;
         ST_WAIT: if (wait_last) nstate = ST_XFER;
         ST_XFER: begin
            if (moved) begin
               if (!frame_i)          nstate = ST_IDLE;
               else if (idx == LAST)  nstate = ST_STOP;
            end
         end
         ST_STOP: if (!frame_i) nstate = ST_IDLE;
         default: nstate = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         is_rd   <= 1'b0;
         idx     <= '0;
         frame_q <= 1'b0;
      end else begin
         state   <= nstate;
         frame_q <= frame_i;
         if ((state == ST_IDLE) && addr_phase && hit) begin
            is_rd <= dec_rd;
            idx   <= dec_idx;
         end else if (moved && frame_i && (idx != LAST)) begin
            idx   <= idx + 1'b1;
         end
      end
   end

   assign sel_o   = (state != ST_IDLE);
   assign trdy_o  = (state == ST_XFER);
   assign stop_o  = (state == ST_STOP);
   assign ad_oe_o = is_rd && ((state == ST_WAIT) || (state == ST_XFER));
   assign we      = moved && !is_rd;
endmodule

// File: rtl/bt_target.sv
module bt_target #(
   parameter int          DW      = 32,
   parameter int          DEPTH   = 16,
   parameter int unsigned BASE    = 64,
   parameter int          RD_WAIT = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          frame_i,
   input  logic [3:0]    cmd_i,
   input  logic          irdy_i,
   input  logic [DW-1:0] ad_i,
   output logic [DW-1:0] ad_o,
   output logic          ad_oe_o,
   output logic          sel_o,
   output logic          trdy_o,
   output logic          stop_o
);
   localparam int IW = $clog2(DEPTH);

   if ((DEPTH < 2) || ((DEPTH & (DEPTH - 1)) != 0)) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 2");
   end
   if ((BASE % DEPTH) != 0) begin : g_bad_base
      $error("BASE must be aligned to DEPTH");
   end
   if ((DW < 8) || (DW > 32) || (DW < IW)) begin : g_bad_dw
      $error("DW must lie in 8..32");
   end
   if ((RD_WAIT < 0) || (RD_WAIT > 64)) begin : g_bad_wait
      $error("RD_WAIT must lie in 0..64");
   end

   logic          hit;
   logic          dec_rd;
   logic [IW-1:0] dec_idx;
   logic          we;
   logic [IW-1:0] idx;
   logic [DW-1:0] rdata;

   bt_decode #(.DW(DW), .DEPTH(DEPTH), .BASE(BASE)) u_dec (
      .addr  (ad_i),
      .cmd   (cmd_i),
      .hit   (hit),
      .is_rd (dec_rd),
      .idx   (dec_idx)
   );

   bt_ctrl #(.DEPTH(DEPTH), .RD_WAIT(RD_WAIT)) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .frame_i (frame_i),
      .irdy_i  (irdy_i),
      .hit     (hit),
      .dec_rd  (dec_rd),
      .dec_idx (dec_idx),
      .sel_o   (sel_o),
      .trdy_o  (trdy_o),
      .stop_o  (stop_o),
      .ad_oe_o (ad_oe_o),
      .we      (we),
      .idx     (idx)
   );

   bt_regfile #(.DW(DW), .DEPTH(DEPTH)) u_rf (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (we),
      .widx  (idx),
      .wdata (ad_i),
      .ridx  (idx),
      .rdata (rdata)
   );

   assign ad_o = ad_oe_o ? rdata : '0;
endmodule

// File: rtl/bt_target_chk.sv
module bt_target_chk #(
   parameter int RD_WAIT = 2
) (
   input logic clk,
   input logic rst_n,
   input logic frame_i,
   input logic irdy_i,
   input logic sel_o,
   input logic trdy_o,
   input logic stop_o,
   input logic ad_oe_o
);
   always @(posedge clk) begin
      if (!rst_n) begin
         p_reset_quiet_r1: assert (!sel_o && !trdy_o && !stop_o && !ad_oe_o)
            else $error("outputs active in reset");
      end
   end

   p_ready_stop_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(trdy_o && stop_o));

   p_drive_needs_claim_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (trdy_o || stop_o || ad_oe_o) |-> sel_o);

   p_turnaround_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ad_oe_o) |-> $past(sel_o));

   p_final_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (trdy_o && irdy_i && !frame_i) |=> !sel_o);

   p_stop_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_o && frame_i) |=> stop_o);

   p_stop_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_o && !frame_i) |=> !sel_o);

   if (RD_WAIT > 0) begin : g_wait_chk
      p_read_wait_r7: assert property (@(posedge clk) disable iff (!rst_n)
         (ad_oe_o && $rose(trdy_o)) |-> $past(ad_oe_o));
   end
endmodule

bind bt_target bt_target_chk #(.RD_WAIT(RD_WAIT)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .frame_i (frame_i),
   .irdy_i  (irdy_i),
   .sel_o   (sel_o),
   .trdy_o  (trdy_o),
   .stop_o  (stop_o),
   .ad_oe_o (ad_oe_o)
);

// File: tb/sim_bt_target.sv
module sim_bt_target;
   localparam int DW      = 32;
   localparam int DEPTH   = 16;
   localparam int BASE    = 64;
   localparam int RD_WAIT = 2;
   localparam logic [3:0] C_RD  = 4'b0110;
   localparam logic [3:0] C_WR  = 4'b0111;
   localparam logic [3:0] C_BAD = 4'b0010;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          frame = 1'b0;
   logic [3:0]    cmd = '0;
   logic          irdy = 1'b0;
   logic [DW-1:0] ad_in = '0;
   logic [DW-1:0] ad_out;
   logic          oe, sel, trdy, stop;

   int n_chk = 0;
   int n_fail = 0;
   logic [DW-1:0] model [DEPTH];

   always #10 clk = ~clk;

   bt_target #(.DW(DW), .DEPTH(DEPTH), .BASE(BASE), .RD_WAIT(RD_WAIT)) u0 (
      .clk(clk), .rst_n(rst_n), .frame_i(frame), .cmd_i(cmd), .irdy_i(irdy),
      .ad_i(ad_in), .ad_o(ad_out), .ad_oe_o(oe), .sel_o(sel), .trdy_o(trdy),
      .stop_o(stop)
   );

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic bit claims(input logic [3:0] c, input int a);
      return (a >= BASE) && (a < BASE + DEPTH) && ((c == C_RD) || (c == C_WR));
   endfunction

   function automatic bit exp_trdy(input bit rd, input int cyc);
      return rd ? (cyc >= RD_WAIT + 2) : 1'b1;
   endfunction

   task automatic burst(input logic [3:0] c, input int a, input int n);
      int idx; int done; int cyc; bit rd; bit stop_pend; bit last_sent;
      rd = (c == C_RD);
      @(negedge clk);
      frame = 1'b1; cmd = c; ad_in = DW'(a); irdy = 1'b0;
      @(negedge clk);
      cmd = '0; ad_in = '0;
      if (!claims(c, a)) begin
         frame = 1'b0;
         for (int k = 0; k < 3; k++) begin
            chk(!sel && !trdy && !stop && !oe, "R3 ignored outputs",
                {sel, trdy, stop, oe}, 0);
            @(negedge clk);
         end
         return;
      end
      chk(sel == 1'b1, "R2 claim", sel, 1);
      idx = a - BASE; done = 0; cyc = 1; stop_pend = 0; last_sent = 0;
      forever begin
         if (!last_sent) begin
            irdy = ($urandom_range(0, 3) != 0);
            if (irdy && (done == n - 1)) begin
               frame = 1'b0;
               last_sent = 1;
            end
         end
         if (!rd) ad_in = $urandom;
         chk(stop == stop_pend, "R9 stop at window top", stop, stop_pend);
         if (stop_pend) begin
            chk(trdy == 1'b0, "R10 trdy with stop", trdy, 0);
            frame = 1'b0; irdy = 1'b0;
            @(negedge clk);
            chk(!sel && !stop, "R9 release after stop", {sel, stop}, 0);
            return;
         end
         chk(trdy == exp_trdy(rd, cyc), rd ? "R7 read wait" : "R4 write ready",
             trdy, exp_trdy(rd, cyc));
         if (rd) chk(oe == (cyc >= 2), "R6 turnaround", oe, (cyc >= 2));
         else    chk(oe == 1'b0, "R10 no drive on write", oe, 0);
         if (trdy && irdy) begin
            if (rd) chk(ad_out == model[idx], "R7 R5 read data", ad_out, model[idx]);
            else    model[idx] = ad_in;
            done++;
            if (!frame) begin
               @(negedge clk);
               irdy = 1'b0;
               chk(!sel && !trdy && !oe, "R8 end after final", {sel, trdy, oe}, 0);
               return;
            end
            if (idx == DEPTH - 1) stop_pend = 1;
            else idx++;
         end
         @(negedge clk);
         cyc++;
      end
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
   end

   initial begin
      for (int i = 0; i < DEPTH; i++) model[i] = '0;
      repeat (3) @(negedge clk);
      chk(!sel && !trdy && !stop && !oe, "R1 reset outputs", {sel, trdy, stop, oe}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!sel && !trdy && !stop && !oe, "R1 idle after reset", {sel, trdy, stop, oe}, 0);
      // R1: storage cleared, and full-window read ends exactly at the top word
      burst(C_RD, BASE, DEPTH);
      // final transfer and window top on the same edge, write side
      burst(C_WR, BASE, DEPTH);
      burst(C_RD, BASE, DEPTH);
      // disconnect at window top (R9)
      burst(C_WR, BASE + DEPTH - 3, 6);
      burst(C_RD, BASE + DEPTH - 2, 5);
      burst(C_WR, BASE + DEPTH - 1, 1);
      // R3: misses and unsupported command must not touch storage
      burst(C_WR, BASE + DEPTH, 4);
      burst(C_WR, BASE - 1, 4);
      burst(C_BAD, BASE + 2, 4);
      burst(C_RD, BASE, DEPTH);
      for (int t = 0; t < 40; t++) begin
         logic [3:0] c;
         int a;
         c = ($urandom_range(0, 9) == 0) ? C_BAD : (($urandom_range(0, 1) != 0) ? C_WR : C_RD);
         a = BASE - 2 + int'($urandom_range(0, DEPTH + 3));
         burst(c, a, int'($urandom_range(1, 8)));
      end
      burst(C_RD, BASE, DEPTH);
      repeat (2) @(negedge clk);
      summary();
      $finish;
   end

   initial begin
      void'($urandom(32'd1234));
   end
endmodule